// File: doc/BRIEF.md
# Bus Wait-State Generator

This block sits between one bus master and one slave and produces the stall (waitrequest) signal that the master sees. Address, write data, the active-low read and write strobes, and the read data coming back all pass straight through with no register in the path. Only the stall signal is shaped here.

A parameter picks one of two variants at elaboration. In the slave-driven variant, the slave has its own stall output, and the block hands it to the master unchanged. In the counted variant, the slave has no stall output. The block then stalls every read or write for a fixed, parameterised number of cycles. A command is active while either strobe is low. The master must hold the command until it sees the stall low, and the transfer completes in the cycle where the stall is low.

Top module: `wsg_top`

## Requirements
- R1: Counted variant with WAIT_N > 0: in the first cycle of a command (the previous cycle was idle, or just completed a transfer), the stall is high in that same cycle, with no register delay.
- R2: Counted variant: while a command is held, the stall stays high for exactly WAIT_N consecutive cycles and then goes low for exactly one cycle, which completes the transfer.
- R3: Counted variant: if the command is still active in the cycle after a completion, it counts as a new transfer and again receives the full WAIT_N stall cycles.
- R4: Counted variant: if the command is withdrawn partway through the wait, the count is discarded, and the next command gets the full WAIT_N cycles.
- R5: Counted variant with WAIT_N = 0: the stall is never asserted, so every command cycle completes a transfer.
- R6: Slave-driven variant: in every cycle, the master-side stall equals the slave's stall input.
- R7: Address, write data, read strobe, write strobe (each active low, 0 = asserted) and read data appear unchanged on the opposite side in the same cycle.
- R8: After reset, and whenever no command is active, the counted variant holds the stall low.
- R9: Reads, writes, and a command whose type changes between reads and writes while it is held are all timed identically, by command activity alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | ADDR_W | Address from the master |
| m_wdata | input | DATA_W | Write data from the master |
| m_rd_n | input | 1 | Master read strobe, active low |
| m_wr_n | input | 1 | Master write strobe, active low |
| m_rdata | output | DATA_W | Read data returned to the master |
| m_wait | output | 1 | Stall seen by the master |
| s_addr | output | ADDR_W | Address to the slave |
| s_wdata | output | DATA_W | Write data to the slave |
| s_rd_n | output | 1 | Slave read strobe, active low |
| s_wr_n | output | 1 | Slave write strobe, active low |
| s_rdata | input | DATA_W | Read data from the slave |
| s_wait | input | 1 | Stall from the slave (used only in the slave-driven variant) |

## Verification
Two events can fall in the same cycle: the completion of one transfer and the start of the next. When the master holds its strobe low past a completion, the cycle after the release must count as a fresh first cycle and stall at once. The bench provokes this by holding commands for every length from one cycle up to more than twice WAIT_N + 1, so completions run straight into new transfers. Every cycle is judged against the stall pattern computed from the position inside the hold. Short holds that are dropped mid-wait exercise the discarded count.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    typedef enum logic {
        WS_SLAVE_DRIVEN = 1'b0,
        WS_COUNTED      = 1'b1
    } ws_mode_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } ws_cmd_t;

    function automatic int unsigned ws_cnt_width(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((32'd1 << w) <= n) w++;
        return w;
    endfunction

    function automatic logic ws_is_active(input ws_cmd_t c);
        return c.rd | c.wr;
    endfunction

endpackage

// File: rtl/wsg_cmd_decode.sv
module wsg_cmd_decode
    import wsg_pkg::*;
(
    input  logic    rd_n,
    input  logic    wr_n,
    output ws_cmd_t cmd,
    output logic    active
);
    always_comb begin
        cmd.rd = ~rd_n;
        cmd.wr = ~wr_n;
        active = ws_is_active(cmd);
    end
endmodule

// File: rtl/wsg_path.sv
module wsg_path #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic              m_rd_n,
    input  logic              m_wr_n,
    output logic [DATA_W-1:0] m_rdata,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    output logic              s_rd_n,
    output logic              s_wr_n,
    input  logic [DATA_W-1:0] s_rdata
);
    always_comb begin
        s_addr  = m_addr;
        s_wdata = m_wdata;
        s_rd_n  = m_rd_n;
        s_wr_n  = m_wr_n;
        m_rdata = s_rdata;
    end
endmodule

// File: rtl/wsg_fixed_timer.sv
module wsg_fixed_timer
    import wsg_pkg::*;
#(
    parameter int unsigned WAIT_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic stall
);
    localparam int unsigned CNT_W = ws_cnt_width(WAIT_N);

    generate
        if (WAIT_N == 0) begin : g_none
            logic unused_in;
            assign unused_in = clk ^ rst ^ active;
            assign stall = 1'b0;
        end else begin : g_count
            localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_N);
            logic [CNT_W-1:0] cnt_q;

            // Stall while the command has not yet spent LIMIT cycles waiting.
            assign stall = active && (cnt_q != LIMIT);

            always_ff @(posedge clk) begin
                if (rst || !active) begin
                    cnt_q <= '0;
                end else if (stall) begin
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    cnt_q <= '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wsg_top.sv
module wsg_top
    import wsg_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter ws_mode_e    MODE   = WS_COUNTED,
    parameter int unsigned WAIT_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic              m_rd_n,
    input  logic              m_wr_n,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_wait,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    output logic              s_rd_n,
    output logic              s_wr_n,
    input  logic [DATA_W-1:0] s_rdata,
    input  logic              s_wait
);
    ws_cmd_t cmd;
    logic    cmd_active;

    wsg_cmd_decode u_dec (
        .rd_n   (m_rd_n),
        .wr_n   (m_wr_n),
        .cmd    (cmd),
        .active (cmd_active)
    );

    wsg_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .m_addr  (m_addr),
        .m_wdata (m_wdata),
        .m_rd_n  (m_rd_n),
        .m_wr_n  (m_wr_n),
        .m_rdata (m_rdata),
        .s_addr  (s_addr),
        .s_wdata (s_wdata),
        .s_rd_n  (s_rd_n),
        .s_wr_n  (s_wr_n),
        .s_rdata (s_rdata)
    );

    generate
        if (MODE == WS_COUNTED) begin : g_counted
            logic unused_sw;
            logic [1:0] unused_cmd;
            assign unused_sw  = s_wait;
            assign unused_cmd = cmd;
            wsg_fixed_timer #(.WAIT_N(WAIT_N)) u_tmr (
                .clk    (clk),
                .rst    (rst),
                .active (cmd_active),
                .stall  (m_wait)
            );
        end else begin : g_slave
            logic unused_st;
            assign unused_st = clk ^ rst ^ cmd_active ^ cmd.rd;
            assign m_wait = s_wait;
        end
    endgenerate
endmodule

// File: rtl/wsg_chk.sv
module wsg_chk
    import wsg_pkg::*;
#(
    parameter ws_mode_e    MODE   = WS_COUNTED,
    parameter int unsigned WAIT_N = 2
) (
    input logic clk,
    input logic rst,
    input logic m_rd_n,
    input logic m_wr_n,
    input logic m_wait,
    input logic s_wait
);
    logic act;
    logic prev_act;
    logic prev_done;
    int unsigned run;

    assign act = !m_rd_n || !m_wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_act  <= 1'b0;
            prev_done <= 1'b0;
            run       <= 0;
        end else begin
            prev_act  <= act;
            prev_done <= act && !m_wait;
            run       <= (act && m_wait) ? run + 1 : 0;
        end
    end

    generate
        if (MODE == WS_COUNTED) begin : g_counted
            AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
                !act |-> !m_wait); // R8
            if (WAIT_N == 0) begin : g_zero
                AST_ZERO_NEVER: assert property (@(posedge clk) disable iff (rst)
                    !m_wait); // R5
            end else begin : g_pos
                AST_FIRST_STALL: assert property (@(posedge clk) disable iff (rst)
                    (act && !prev_act) |-> m_wait); // R1 R4
                AST_REARM: assert property (@(posedge clk) disable iff (rst)
                    (act && prev_done) |-> m_wait); // R3
                AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
                    (act && m_wait) |-> (run < WAIT_N)); // R2
                AST_RUN_RELEASE: assert property (@(posedge clk) disable iff (rst)
                    (act && run == WAIT_N) |-> !m_wait); // R2
            end
        end else begin : g_slave
            AST_FOLLOW_SLAVE: assert property (@(posedge clk) disable iff (rst)
                m_wait == s_wait); // R6
        end
    endgenerate
endmodule

bind wsg_top wsg_chk #(.MODE(MODE), .WAIT_N(WAIT_N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .m_rd_n (m_rd_n),
    .m_wr_n (m_wr_n),
    .m_wait (m_wait),
    .s_wait (s_wait)
);

// File: tb/sim_wsg_top.sv
module sim_wsg_top;
    import wsg_pkg::*;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int N  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic m_rd_n = 1'b1, m_wr_n = 1'b1;
    logic [DW-1:0] s_rdata = '0;
    logic s_wait = 1'b0;

    logic [DW-1:0] rd0, rd1, rd2;
    logic w0, w1, w2;
    logic [AW-1:0] a0, a1, a2;
    logic [DW-1:0] d0, d1, d2;
    logic r0, r1, r2, x0, x1, x2;

    wsg_top #(.ADDR_W(AW), .DATA_W(DW), .MODE(WS_COUNTED), .WAIT_N(N)) u0 (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_rd_n(m_rd_n),
        .m_wr_n(m_wr_n), .m_rdata(rd0), .m_wait(w0), .s_addr(a0), .s_wdata(d0),
        .s_rd_n(r0), .s_wr_n(x0), .s_rdata(s_rdata), .s_wait(s_wait));
    wsg_top #(.ADDR_W(AW), .DATA_W(DW), .MODE(WS_COUNTED), .WAIT_N(0)) u1 (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_rd_n(m_rd_n),
        .m_wr_n(m_wr_n), .m_rdata(rd1), .m_wait(w1), .s_addr(a1), .s_wdata(d1),
        .s_rd_n(r1), .s_wr_n(x1), .s_rdata(s_rdata), .s_wait(s_wait));
    wsg_top #(.ADDR_W(AW), .DATA_W(DW), .MODE(WS_SLAVE_DRIVEN), .WAIT_N(N)) u2 (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_rd_n(m_rd_n),
        .m_wr_n(m_wr_n), .m_rdata(rd2), .m_wait(w2), .s_addr(a2), .s_wdata(d2),
        .s_rd_n(r2), .s_wr_n(x2), .s_rdata(s_rdata), .s_wait(s_wait));

    int total = 0;
    int bad = 0;
    bit reported = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Drive one cycle at the falling edge, check combinational outputs just after.
    // k is the cycle index within a continuous hold (-1 = idle).
    task automatic step(input int k, input bit rd, input bit wr, input int seed);
        logic ew0;
        @(negedge clk);
        m_rd_n  = ~rd;
        m_wr_n  = ~wr;
        m_addr  = AW'(seed * 37 + 5);
        m_wdata = DW'(seed * 911 + 3);
        s_rdata = DW'(seed * 4099 + 17);
        s_wait  = seed[0] ^ seed[2];
        #1;
        ew0 = (k >= 0) && ((k % (N + 1)) != N);
        if (k < 0) check(w0 == 1'b0, "R8", 32'(w0), 32'(0));
        else if (k % (N + 1) == 0) check(w0 == ew0, "R1/R3", 32'(w0), 32'(ew0));
        else check(w0 == ew0, "R2", 32'(w0), 32'(ew0));
        check(w1 == 1'b0, "R5", 32'(w1), 32'(0));
        check(w2 == s_wait, "R6", 32'(w2), 32'(s_wait));
        check(a0 == m_addr && a1 == m_addr && a2 == m_addr, "R7 addr", 32'(a0), 32'(m_addr));
        check(d0 == m_wdata && d2 == m_wdata, "R7 wdata", 32'(d0), 32'(m_wdata));
        check(r0 == m_rd_n && x0 == m_wr_n && r2 == m_rd_n && x1 == m_wr_n,
              "R7 strobes", {30'(0), r0, x0}, {30'(0), m_rd_n, m_wr_n});
        check(rd0 == s_rdata && rd1 == s_rdata && rd2 == s_rdata, "R7 rdata", 32'(rd0), 32'(s_rdata));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 32'(0), 32'(1));
        report();
    end

    initial begin
        int seed = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state, bus idle
        step(-1, 0, 0, seed++);
        step(-1, 0, 0, seed++);
        // Sweep hold lengths: 0=read, 1=write, 2=alternating type (R9), R4 via short holds
        for (int kind = 0; kind < 3; kind++) begin
            for (int len = 1; len <= 2 * (N + 1) + 2; len++) begin
                for (int k = 0; k < len; k++) begin
                    bit rd, wr;
                    rd = (kind == 0) || (kind == 2 && k[0] == 1'b0);
                    wr = (kind == 1) || (kind == 2 && k[0] == 1'b1);
                    step(k, rd, wr, seed++);
                end
                step(-1, 0, 0, seed++); // R4: next hold restarts the count
            end
        end
        // Both strobes low at once is still one command (R9)
        for (int k = 0; k < N + 2; k++) step(k, 1, 1, seed++);
        step(-1, 0, 0, seed++);
        // Reset in mid-wait clears the count (R8)
        step(0, 1, 0, seed++);
        step(1, 1, 0, seed++);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; m_rd_n = 1'b1; m_wr_n = 1'b1;
        step(-1, 0, 0, seed++);
        for (int k = 0; k < N + 1; k++) step(k, 0, 1, seed++);
        step(-1, 0, 0, seed++);
        report();
    end
endmodule